// File: doc/BRIEF.md
# Per-Packet Repeater Statistics Classifier

This block sits beside a multiport repeater and watches the nibble-wide stream that the repeater transmits, together with its ready framing strobe, transmit error line, inter-repeater collision and data-valid lines, and a side-band management nibble bus. For every carrier event it finds out which controller and port the activity came from, measures the carrier in nibbles, detects the start-of-frame delimiter, counts octets, runs a serial CRC-32 over the frame and captures the source address. When the carrier ends, it emits a one-clock strobe that hands a full set of classification flags, the octet and nibble counts, the source identity and the captured source address to a later update stage. That stage owns per-port storage.

Three 32-bit aggregate counters cover all ports: collision events, false carrier events and network utilization in ready cycles. Statistics gathering only runs while an enable input is high. While gathering is disabled, the carrier nibble counter can be preset for test, and the next carrier continues from the preset value. The management bus is taken to be synchronous to the local clock.

Top module: `rstat_classifier`

## Requirements
- R1: While `gather_en` and `tx_rdy` are high, one nibble of `txd` is taken on every clock. `eoc_valid` pulses for exactly one clock, on the edge after the first clock that samples `tx_rdy` low. In that same clock `eoc_nibbles`, `eoc_octets`, `eoc_ctrl`, `eoc_port`, `eoc_sa` and all `f_*` flags show the finished event, and they hold until the next pulse.
- R2: `f_runt` is set when the carrier lasted 141 nibbles or fewer, with no collision and no false carrier. `f_frame` needs at least 64 octets after the delimiter, so events of 142 and 143 nibbles are neither runt nor frame.
- R3: When `irb_dv` is low in the first ready clock of a carrier, `f_fcar` is set for that event and `cnt_fc` rises by one.
- R4: The delimiter is a nibble 0x5 followed directly by a nibble 0xD. Octets are counted only after it, and each octet is built low nibble first.
- R5: A reflected CRC-32 (polynomial 0xEDB88320, preset all ones) runs over every nibble after the delimiter. A correct frame leaves the residue 0xDEBB20E3. For 64 to 1518 octets with no collision: an even nibble count with a good residue gives `f_frame`; an even count with a bad residue gives `f_fcs`; an odd count with a bad residue gives `f_align`.
- R6: `f_long` is set when more than 1518 octets follow the delimiter and there was no collision.
- R7: `f_vle` is set when the carrier nibble count exceeds 4000.
- R8: `f_rate` is set when `mg_err` was seen in any ready clock. `f_sym` is set when `tx_err` was seen in a ready clock of an event with at least 64 octets and no collision.
- R9: Octets 6 to 11 after the delimiter form `eoc_sa`, with the first of them in bits 47:40. For events with at least 64 octets and no collision, `f_sachg` is set when this address differs from `prev_sa` at end of carrier.
- R10: The first `mg_nib` nibble taken with `mg_dv` and `tx_rdy` both high gives `eoc_ctrl`, and the second gives `eoc_port`. `mg_dv` outside the ready window is ignored. An event that has no such nibbles reports 0 for both.
- R11: `cnt_col` rises by one for each rising edge of `irb_col` inside the ready window. `cnt_util` rises by one for every gathered ready clock.
- R12: With `gather_en` low, no event is processed and no counter moves. `preset_we` loads `preset_val` into the carrier counter only while gathering is disabled, and it is ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| gather_en | input | 1 | Statistics gathering enable |
| preset_we | input | 1 | Carrier counter preset strobe |
| preset_val | input | 14 | Carrier counter preset value |
| tx_rdy | input | 1 | Ready framing strobe of the transmit stream |
| txd | input | 4 | Transmit nibble |
| tx_err | input | 1 | Transmit error |
| irb_col | input | 1 | Inter-repeater collision |
| irb_dv | input | 1 | Inter-repeater data valid |
| mg_dv | input | 1 | Management data valid |
| mg_nib | input | 4 | Management nibble (controller, then port) |
| mg_err | input | 1 | Management rate-mismatch error |
| prev_sa | input | 48 | Last stored source address for the reported port |
| eoc_valid | output | 1 | End-of-carrier strobe |
| f_frame | output | 1 | Good frame |
| f_runt | output | 1 | Runt |
| f_long | output | 1 | Frame too long |
| f_fcs | output | 1 | FCS error |
| f_align | output | 1 | Alignment error |
| f_vle | output | 1 | Very long event |
| f_sym | output | 1 | Symbol error |
| f_rate | output | 1 | Rate mismatch |
| f_sachg | output | 1 | Source address change |
| f_fcar | output | 1 | False carrier |
| eoc_octets | output | 16 | Octets after the delimiter |
| eoc_nibbles | output | 14 | Carrier length in nibbles |
| eoc_ctrl | output | 4 | Source controller |
| eoc_port | output | 4 | Source port |
| eoc_sa | output | 48 | Captured source address |
| cnt_col | output | 32 | Aggregate collision events |
| cnt_fc | output | 32 | Aggregate false carriers |
| cnt_util | output | 32 | Aggregate ready clocks |

## Verification
False-carrier detection and collision counting can both fire in the first ready clock of a carrier, and both aggregate counters then step on the same edge. The bench provokes this by starting an event with `irb_dv` low and `irb_col` already high. It judges the result by requiring `cnt_fc` and `cnt_col` to each rise by exactly one, with `f_fcar` set and `f_runt` clear. A near-exhaustive sweep of carrier lengths around the 141-nibble runt ceiling covers the runt/frame boundary.

// File: rtl/rstat_pkg.sv
package rstat_pkg;

  localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;
  localparam logic [3:0]  PRE_NIB     = 4'h5;
  localparam logic [3:0]  SFD_NIB     = 4'hD;

  typedef struct packed {
    logic frame;
    logic runt;
    logic too_long;
    logic fcs;
    logic align;
    logic vle;
    logic sym;
    logic rate;
    logic sachg;
    logic fcar;
  } rstat_flags_t;

  // Four serial CRC steps, least significant bit of the nibble first.
  function automatic logic [31:0] crc_nibble(input logic [31:0] c, input logic [3:0] n);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 4; b++) begin
      if (r[0] ^ n[b]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic rstat_flags_t classify(
    input int unsigned car, input int unsigned oct, input logic sfd, input logic odd,
    input logic [31:0] crc, input logic col, input logic err, input logic mer,
    input logic fc, input logic sa_diff,
    input int unsigned runt_nib, input int unsigned min_oct,
    input int unsigned max_oct, input int unsigned vle_nib);
    rstat_flags_t f;
    logic big, legal, crc_ok;
    big    = sfd && (oct >= min_oct) && !col;
    legal  = big && (oct <= max_oct);
    crc_ok = (crc == CRC_RESIDUE);
    f.frame    = legal && !odd && crc_ok;
    f.runt     = (car <= runt_nib) && !col && !fc;
    f.too_long = sfd && (oct > max_oct) && !col;
    f.fcs      = legal && !odd && !crc_ok;
    f.align    = legal && odd && !crc_ok;
    f.vle      = (car > vle_nib);
    f.sym      = err && big;
    f.rate     = mer;
    f.sachg    = big && sa_diff;
    f.fcar     = fc;
    return f;
  endfunction

endpackage

// File: rtl/rstat_rx_track.sv
module rstat_rx_track import rstat_pkg::*; #(
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nib_valid,
  input  logic [3:0]    nib,
  input  logic          clr,
  output logic          sfd_seen,
  output logic [OW-1:0] octets,
  output logic          odd,
  output logic [31:0]   crc,
  output logic [47:0]   sa
);
  localparam logic [OW-1:0] OCT_MAX = {OW{1'b1}};
  localparam int SA_FIRST = 6;
  localparam int SA_LAST  = 11;

  logic [3:0] prev_nib;
  logic [3:0] lo_nib;
  logic [7:0] byte_w;
  logic       sfd_hit;
  logic       sa_take;

  assign byte_w  = {nib, lo_nib};
  assign sfd_hit = nib_valid && !sfd_seen && (prev_nib == PRE_NIB) && (nib == SFD_NIB);
  assign sa_take = (32'(octets) >= SA_FIRST) && (32'(octets) <= SA_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sfd_seen <= 1'b0; octets <= '0; odd <= 1'b0; crc <= '1;
      sa <= '0; prev_nib <= '0; lo_nib <= '0;
    end else if (clr) begin
      sfd_seen <= 1'b0; octets <= '0; odd <= 1'b0; crc <= '1;
      sa <= '0; prev_nib <= '0; lo_nib <= '0;
    end else if (nib_valid) begin
      prev_nib <= nib;
      if (sfd_hit) begin
        sfd_seen <= 1'b1;
        crc      <= '1;
      end else if (sfd_seen) begin
        crc <= crc_nibble(crc, nib);
        if (!odd) begin
          lo_nib <= nib;
          odd    <= 1'b1;
        end else begin
          odd <= 1'b0;
          if (octets != OCT_MAX) octets <= octets + 1'b1;
          if (sa_take) sa <= {sa[39:0], byte_w};
        end
      end
    end
  end

  p_no_octets_before_sfd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sfd_seen |=> (octets == '0));

endmodule

// File: rtl/rstat_src_latch.sv
module rstat_src_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic [3:0] nib,
  input  logic       clr,
  output logic [3:0] ctrl,
  output logic [3:0] port
);
  logic [1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0; ctrl <= '0; port <= '0;
    end else if (clr) begin
      idx <= '0; ctrl <= '0; port <= '0;
    end else if (take) begin
      case (idx)
        2'd0:    begin ctrl <= nib; idx <= 2'd1; end
        2'd1:    begin port <= nib; idx <= 2'd2; end
        default: idx <= idx;
      endcase
    end
  end

  p_src_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clr) |=> ($stable(ctrl) && $stable(port)));

endmodule

// File: rtl/rstat_aggr.sv
module rstat_aggr #(
  parameter int W = 32,
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] inc,
  output logic [W-1:0] cnt [N]
);
  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt[i] <= '0;
      else if (inc[i]) cnt[i] <= cnt[i] + 1'b1;
    end

    p_cnt_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      inc[i] |=> (cnt[i] == $past(cnt[i]) + 1'b1));
    p_cnt_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !inc[i] |=> $stable(cnt[i]));
  end

endmodule

// File: rtl/rstat_classifier.sv
module rstat_classifier import rstat_pkg::*; #(
  parameter int CW       = 14,
  parameter int OW       = 16,
  parameter int CNTW     = 32,
  parameter int RUNT_NIB = 141,
  parameter int MIN_OCT  = 64,
  parameter int MAX_OCT  = 1518,
  parameter int VLE_NIB  = 4000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gather_en,
  input  logic            preset_we,
  input  logic [CW-1:0]   preset_val,
  input  logic            tx_rdy,
  input  logic [3:0]      txd,
  input  logic            tx_err,
  input  logic            irb_col,
  input  logic            irb_dv,
  input  logic            mg_dv,
  input  logic [3:0]      mg_nib,
  input  logic            mg_err,
  input  logic [47:0]     prev_sa,
  output logic            eoc_valid,
  output logic            f_frame,
  output logic            f_runt,
  output logic            f_long,
  output logic            f_fcs,
  output logic            f_align,
  output logic            f_vle,
  output logic            f_sym,
  output logic            f_rate,
  output logic            f_sachg,
  output logic            f_fcar,
  output logic [OW-1:0]   eoc_octets,
  output logic [CW-1:0]   eoc_nibbles,
  output logic [3:0]      eoc_ctrl,
  output logic [3:0]      eoc_port,
  output logic [47:0]     eoc_sa,
  output logic [CNTW-1:0] cnt_col,
  output logic [CNTW-1:0] cnt_fc,
  output logic [CNTW-1:0] cnt_util
);
  localparam logic [CW-1:0] CAR_MAX = {CW{1'b1}};
  localparam int NCNT = 3;

  // Named internal events
  logic nib_valid, start, eoc_go, col_ev, fc_ev;
  logic in_car, col_q;
  logic col_seen, err_seen, mer_seen, fc_seen;
  logic [CW-1:0] car_cnt;

  logic          sfd_seen, odd;
  logic [OW-1:0] octets;
  logic [31:0]   crc;
  logic [47:0]   sa;
  logic [3:0]    ctrl, port;
  rstat_flags_t  fl, fl_q;
  logic [CNTW-1:0] cnt [NCNT];

  assign nib_valid = gather_en && tx_rdy;
  assign start     = nib_valid && !in_car;
  assign eoc_go    = in_car && !tx_rdy;
  assign col_ev    = nib_valid && irb_col && !col_q;
  assign fc_ev     = start && !irb_dv;

  rstat_rx_track #(.OW(OW)) u_rx (
    .clk(clk), .rst_n(rst_n), .nib_valid(nib_valid), .nib(txd), .clr(eoc_go),
    .sfd_seen(sfd_seen), .octets(octets), .odd(odd), .crc(crc), .sa(sa)
  );

  rstat_src_latch u_src (
    .clk(clk), .rst_n(rst_n), .take(nib_valid && mg_dv), .nib(mg_nib),
    .clr(eoc_go), .ctrl(ctrl), .port(port)
  );

  rstat_aggr #(.W(CNTW), .N(NCNT)) u_aggr (
    .clk(clk), .rst_n(rst_n), .inc({nib_valid, fc_ev, col_ev}), .cnt(cnt)
  );

  assign cnt_col  = cnt[0];
  assign cnt_fc   = cnt[1];
  assign cnt_util = cnt[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_car <= 1'b0; col_q <= 1'b0; car_cnt <= '0;
      col_seen <= 1'b0; err_seen <= 1'b0; mer_seen <= 1'b0; fc_seen <= 1'b0;
    end else begin
      col_q <= nib_valid && irb_col;
      if (eoc_go) begin
        in_car <= 1'b0; car_cnt <= '0;
        col_seen <= 1'b0; err_seen <= 1'b0; mer_seen <= 1'b0; fc_seen <= 1'b0;
      end else if (nib_valid) begin
        in_car <= 1'b1;
        if (car_cnt != CAR_MAX) car_cnt <= car_cnt + 1'b1;
        col_seen <= col_seen | irb_col;
        err_seen <= err_seen | tx_err;
        mer_seen <= mer_seen | mg_err;
        if (start) fc_seen <= !irb_dv;
      end else if (!gather_en && preset_we) begin
        car_cnt <= preset_val;
      end
    end
  end

  assign fl = classify(32'(car_cnt), 32'(octets), sfd_seen, odd, crc, col_seen,
                       err_seen, mer_seen, fc_seen, (sa != prev_sa),
                       RUNT_NIB, MIN_OCT, MAX_OCT, VLE_NIB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_valid <= 1'b0; fl_q <= '0; eoc_octets <= '0; eoc_nibbles <= '0;
      eoc_ctrl <= '0; eoc_port <= '0; eoc_sa <= '0;
    end else begin
      eoc_valid <= eoc_go;
      if (eoc_go) begin
        fl_q        <= fl;
        eoc_octets  <= octets;
        eoc_nibbles <= car_cnt;
        eoc_ctrl    <= ctrl;
        eoc_port    <= port;
        eoc_sa      <= sa;
      end
    end
  end

  assign f_frame = fl_q.frame;
  assign f_runt  = fl_q.runt;
  assign f_long  = fl_q.too_long;
  assign f_fcs   = fl_q.fcs;
  assign f_align = fl_q.align;
  assign f_vle   = fl_q.vle;
  assign f_sym   = fl_q.sym;
  assign f_rate  = fl_q.rate;
  assign f_sachg = fl_q.sachg;
  assign f_fcar  = fl_q.fcar;

  p_eoc_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_valid |=> !eoc_valid);
  p_runt_frame_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_valid |-> !(f_runt && f_frame));
  p_fcar_counted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_valid && f_fcar) |-> (cnt_fc != '0));
  p_crc_class_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_valid |-> $onehot0({f_frame, f_fcs, f_align, f_long}));
  p_preset_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (gather_en && !nib_valid && !eoc_go) |=> $stable(car_cnt));

endmodule

// File: tb/rstat_classifier_tb.sv
module rstat_classifier_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gather_en = 1'b0, preset_we = 1'b0;
  logic [13:0] preset_val = '0;
  logic tx_rdy = 1'b0, tx_err = 1'b0, irb_col = 1'b0, irb_dv = 1'b1;
  logic mg_dv = 1'b0, mg_err = 1'b0;
  logic [3:0] txd = '0, mg_nib = '0;
  logic [47:0] prev_sa = '0;
  logic eoc_valid, f_frame, f_runt, f_long, f_fcs, f_align, f_vle, f_sym, f_rate, f_sachg, f_fcar;
  logic [15:0] eoc_octets;
  logic [13:0] eoc_nibbles;
  logic [3:0] eoc_ctrl, eoc_port;
  logic [47:0] eoc_sa;
  logic [31:0] cnt_col, cnt_fc, cnt_util;

  int n_chk = 0, n_fail = 0;
  bit got_eoc;
  logic [7:0] buf_b [0:2047];
  longint util_exp = 0;

  always #4 clk = ~clk;

  rstat_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .gather_en(gather_en), .preset_we(preset_we),
    .preset_val(preset_val), .tx_rdy(tx_rdy), .txd(txd), .tx_err(tx_err),
    .irb_col(irb_col), .irb_dv(irb_dv), .mg_dv(mg_dv), .mg_nib(mg_nib),
    .mg_err(mg_err), .prev_sa(prev_sa), .eoc_valid(eoc_valid), .f_frame(f_frame),
    .f_runt(f_runt), .f_long(f_long), .f_fcs(f_fcs), .f_align(f_align), .f_vle(f_vle),
    .f_sym(f_sym), .f_rate(f_rate), .f_sachg(f_sachg), .f_fcar(f_fcar),
    .eoc_octets(eoc_octets), .eoc_nibbles(eoc_nibbles), .eoc_ctrl(eoc_ctrl),
    .eoc_port(eoc_port), .eoc_sa(eoc_sa), .cnt_col(cnt_col), .cnt_fc(cnt_fc),
    .cnt_util(cnt_util)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok || act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nib_of(input int i);
    int k;
    if (i < 15) return 4'h5;
    if (i == 15) return 4'hD;
    k = i - 16;
    return (k % 2 == 0) ? buf_b[k/2][3:0] : buf_b[k/2][7:4];
  endfunction

  // Fills nb bytes: payload pattern then a correct FCS in the last four.
  task automatic mk_frame(input int nb, input int seed);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < nb - 4; i++) begin
      buf_b[i] = 8'((i * 7 + seed) & 255);
      c = c ^ {24'h0, buf_b[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    c = ~c;
    for (int j = 0; j < 4; j++) buf_b[nb - 4 + j] = c[8*j +: 8];
  endtask

  function automatic logic [47:0] sa_of();
    return {buf_b[6], buf_b[7], buf_b[8], buf_b[9], buf_b[10], buf_b[11]};
  endfunction

  // One carrier event; index arguments of -1 disable the strobe.
  task automatic run_ev(input int nn, input bit dv0, input int col_a, input int col_b,
                        input int err_at, input int mer_at, input int mdv_at,
                        input logic [3:0] mc, input logic [3:0] mp);
    for (int i = 0; i < nn; i++) begin
      @(negedge clk);
      tx_rdy = 1'b1; txd = nib_of(i); irb_dv = dv0;
      irb_col = (col_a >= 0 && i >= col_a && i < col_a + 3) ||
                (col_b >= 0 && i >= col_b && i < col_b + 3);
      tx_err = (i == err_at);
      mg_err = (i == mer_at);
      mg_dv  = (mdv_at >= 0) && (i == mdv_at || i == mdv_at + 1);
      mg_nib = (i == mdv_at) ? mc : mp;
    end
    if (gather_en) util_exp += nn;
    @(negedge clk);
    tx_rdy = 1'b0; irb_col = 1'b0; tx_err = 1'b0; mg_err = 1'b0; mg_dv = 1'b0; irb_dv = 1'b1;
    @(negedge clk);
    got_eoc = eoc_valid;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] c0, f0;
    repeat (3) @(negedge clk);
    chk(1, "R1 reset eoc", eoc_valid, 0);
    chk(1, "R11 reset counters", cnt_col + cnt_fc + cnt_util, 0);
    rst_n = 1'b1;
    gather_en = 1'b1;
    @(negedge clk);

    // R1 R5 R9 R10: good 64-octet frame
    mk_frame(64, 3);
    prev_sa = sa_of();
    run_ev(16 + 128, 1, -1, -1, -1, -1, 4, 4'd3, 4'd7);
    chk(got_eoc, "R1 eoc pulse", got_eoc, 1);
    chk(1, "R5 frame", f_frame, 1);
    chk(1, "R4 octets", eoc_octets, 64);
    chk(1, "R1 nibbles", eoc_nibbles, 144);
    chk(1, "R10 ctrl", eoc_ctrl, 3);
    chk(1, "R10 port", eoc_port, 7);
    chk(1, "R9 sa", eoc_sa, sa_of());
    chk(1, "R9 no change", f_sachg, 0);
    chk(1, "R2 not runt", f_runt, 0);
    chk(1, "R1 eoc single", eoc_valid, 0);

    // R9 address change
    prev_sa = ~sa_of();
    run_ev(144, 1, -1, -1, -1, -1, -1, 0, 0);
    chk(1, "R9 sa change", f_sachg, 1);
    chk(1, "R10 no mgmt ctrl", eoc_ctrl, 0);
    prev_sa = sa_of();

    // R5 FCS error
    buf_b[20] = buf_b[20] ^ 8'h01;
    run_ev(144, 1, -1, -1, -1, -1, -1, 0, 0);
    chk(1, "R5 fcs", f_fcs, 1);
    chk(1, "R5 fcs not frame", f_frame, 0);

    // R5 alignment: extra nibble
    buf_b[20] = buf_b[20] ^ 8'h01;
    run_ev(145, 1, -1, -1, -1, -1, -1, 0, 0);
    chk(1, "R5 align", f_align, 1);
    chk(1, "R5 align fcs", f_fcs, 0);

    // R8 symbol and rate
    run_ev(144, 1, -1, -1, 60, 70, -1, 0, 0);
    chk(1, "R8 sym", f_sym, 1);
    chk(1, "R8 rate", f_rate, 1);

    // R2 boundary sweep
    mk_frame(64, 9);
    for (int n = 120; n <= 146; n++) begin
      run_ev(n, 1, -1, -1, -1, -1, -1, 0, 0);
      chk(1, "R2 runt sweep", f_runt, (n <= 141) ? 1 : 0);
      chk(1, "R2 frame sweep", f_frame, (n == 144) ? 1 : 0);
    end

    // R2 collision suppresses runt; R11 two collision events
    c0 = cnt_col;
    run_ev(60, 1, 10, 30, -1, -1, -1, 0, 0);
    chk(1, "R2 col runt", f_runt, 0);
    chk(1, "R11 col count", cnt_col - c0, 2);

    // R3 false carrier together with collision at the first ready clock
    c0 = cnt_col; f0 = cnt_fc;
    run_ev(30, 0, 0, -1, -1, -1, -1, 0, 0);
    chk(1, "R3 fcar flag", f_fcar, 1);
    chk(1, "R3 fc count", cnt_fc - f0, 1);
    chk(1, "R11 col same cycle", cnt_col - c0, 1);
    chk(1, "R3 fcar not runt", f_runt, 0);

    // R6 lengths
    mk_frame(1518, 5);
    prev_sa = sa_of();
    run_ev(16 + 2*1518, 1, -1, -1, -1, -1, -1, 0, 0);
    chk(1, "R6 1518 frame", f_frame, 1);
    chk(1, "R6 1518 not long", f_long, 0);
    mk_frame(1519, 5);
    run_ev(16 + 2*1519, 1, -1, -1, -1, -1, -1, 0, 0);
    chk(1, "R6 long", f_long, 1);
    chk(1, "R6 long not frame", f_frame, 0);

    // R7 very long event
    run_ev(4000, 1, -1, -1, -1, -1, -1, 0, 0);
    chk(1, "R7 vle at limit", f_vle, 0);
    run_ev(4001, 1, -1, -1, -1, -1, -1, 0, 0);
    chk(1, "R7 vle", f_vle, 1);

    // R10 stray management nibbles outside ready
    @(negedge clk); mg_dv = 1; mg_nib = 4'd9;
    @(negedge clk); mg_nib = 4'd10;
    @(negedge clk); mg_dv = 0;
    run_ev(40, 1, -1, -1, -1, -1, -1, 0, 0);
    chk(1, "R10 stray ctrl", eoc_ctrl, 0);
    chk(1, "R10 stray port", eoc_port, 0);

    // R11 utilization
    chk(1, "R11 util", cnt_util, util_exp);

    // R12 gating and preset
    gather_en = 1'b0;
    c0 = cnt_util;
    run_ev(60, 1, 5, -1, -1, -1, -1, 0, 0);
    chk(1, "R12 no eoc", got_eoc, 0);
    chk(1, "R12 util frozen", cnt_util, c0);
    @(negedge clk); preset_we = 1; preset_val = 14'd100;
    @(negedge clk); preset_we = 0; gather_en = 1'b1;
    run_ev(42, 1, -1, -1, -1, -1, -1, 0, 0);
    chk(1, "R12 preset nibbles", eoc_nibbles, 142);
    chk(1, "R12 preset no runt", f_runt, 0);
    @(negedge clk); preset_we = 1; preset_val = 14'd500;
    @(negedge clk); preset_we = 0;
    run_ev(50, 1, -1, -1, -1, -1, -1, 0, 0);
    chk(1, "R12 preset ignored", eoc_nibbles, 50);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule